// File: doc/BRIEF.md
# Single-Bit Test and Modify Unit

This block takes one operand, picks one bit of it, and then tests that bit, sets it to one, clears it to zero or inverts it. The zero flag is loaded with the complement of the picked bit as it stood before any change. Every operation does this, including the three that modify the operand. The operand is 32 bits wide in register form. In memory form only the low 8 bits are used, and the upper 24 bits of the result are zero.

The bit number comes from one of two sources, an immediate field or a data-register value, chosen by a select input. Only the low 5 bits (register form) or the low 3 bits (memory form) of the chosen number are used. A request is presented with a one-cycle valid strobe. One clock later the block returns the registered result, a write-enable and the new zero flag, together with a done pulse. The write-enable is low for a test, because a test writes nothing back. The other condition flags are passed through unchanged.

Top module: `bit_tmod_unit`

## Requirements
- R1: After reset, done, wr_en, z_out and result are all 0, and flags_out equals flags_in.
- R2: done is high exactly in the cycle that follows a cycle with valid_in high, and low otherwise.
- R3: Opcode encoding is 2'b00 test, 2'b01 set, 2'b10 clear, 2'b11 change. For every opcode, z_out equals the complement of the selected bit of the operand as it was before modification.
- R4: For set, result equals the operand with the selected bit forced to 1.
- R5: For clear, result equals the operand with the selected bit forced to 0.
- R6: For change, result equals the operand with the selected bit inverted.
- R7: For test, wr_en is 0 and result equals the unmodified operand. For the other three opcodes, wr_en is 1.
- R8: When size_byte is 1 (memory form), only operand bits [7:0] are used, the bit number is taken modulo 8, and result[31:8] is 0.
- R9: When size_byte is 0 (register form), the bit number is taken modulo 32. Upper bits of the bit number have no effect.
- R10: When num_sel is 0 the bit number is imm_num. When num_sel is 1 it is reg_num.
- R11: flags_out (bits N, V, C, X in any fixed order) always equals flags_in. z_out is the only flag this block drives.
- R12: While no result is being delivered, z_out, result and wr_en hold their last values and wr_en is only meaningful with done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_in | input | 1 | Request strobe |
| opcode | input | 2 | 00 test, 01 set, 10 clear, 11 change |
| size_byte | input | 1 | 1 = 8-bit memory form, 0 = 32-bit register form |
| num_sel | input | 1 | 1 = bit number from reg_num, 0 = from imm_num |
| imm_num | input | 8 | Immediate bit number |
| reg_num | input | 32 | Data-register bit number |
| operand | input | 32 | Destination operand |
| flags_in | input | 4 | Other condition flags |
| result | output | 32 | Modified operand |
| wr_en | output | 1 | Write-back enable |
| z_out | output | 1 | Updated zero flag |
| flags_out | output | 4 | Passed-through flags |
| done | output | 1 | Result valid pulse |

## Verification
Two functions land in the same registered cycle: computing the zero flag from the old bit, and writing the modified bit. A set on a bit that is already one, or a clear on a bit that is already zero, is the provoking case. The flag has to reflect the pre-change value even though the result shows the post-change value in that same cycle. The bench forces these cases directly and also meets them in random traffic, and it compares z_out and result against values its own functions compute from the inputs. It also sends requests back to back, so that each done pulse has to carry the result of the request immediately before it.

// File: rtl/bit_tmod_pkg.sv
package bit_tmod_pkg;
  typedef enum logic [1:0] {
    OP_TEST   = 2'b00,
    OP_SET    = 2'b01,
    OP_CLEAR  = 2'b10,
    OP_CHANGE = 2'b11
  } bit_op_e;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned IDX_W  = $clog2(WORD_W);
  localparam int unsigned FLAG_W = 4;
endpackage

// File: rtl/bit_index_sel.sv
module bit_index_sel
  import bit_tmod_pkg::*;
#(
  parameter int unsigned IMM_W = 8,
  parameter int unsigned REG_W = 32
) (
  input  logic             num_sel,
  input  logic             size_byte,
  input  logic [IMM_W-1:0] imm_num,
  input  logic [REG_W-1:0] reg_num,
  output logic [IDX_W-1:0] idx
);
  localparam int unsigned BIDX_W = $clog2(BYTE_W);

  function automatic logic [IDX_W-1:0] reduce_idx(input logic [REG_W-1:0] raw, input logic bsel);
    logic [IDX_W-1:0] r;
    r = raw[IDX_W-1:0];
    if (bsel) r = {{(IDX_W-BIDX_W){1'b0}}, raw[BIDX_W-1:0]};
    return r;
  endfunction

  logic [REG_W-1:0] raw_num;
  always_comb begin
    raw_num = num_sel ? reg_num : REG_W'(imm_num);
    idx = reduce_idx(raw_num, size_byte);
  end

  // R8: a byte-form index stays below 8
  always_comb begin
    if (size_byte) a_byte_idx_r8: assert (idx < IDX_W'(BYTE_W));
  end
endmodule

// File: rtl/bit_alter_core.sv
module bit_alter_core
  import bit_tmod_pkg::*;
(
  input  bit_op_e           op,
  input  logic              size_byte,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] operand,
  output logic [WORD_W-1:0] new_val,
  output logic              old_bit,
  output logic              writes
);
  function automatic logic [WORD_W-1:0] apply_op(input bit_op_e o,
                                                 input logic [WORD_W-1:0] v,
                                                 input logic [IDX_W-1:0] i);
    logic [WORD_W-1:0] m;
    m = WORD_W'(1) << i;
    case (o)
      OP_SET:    return v | m;
      OP_CLEAR:  return v & ~m;
      OP_CHANGE: return v ^ m;
      default:   return v;
    endcase
  endfunction

  logic [WORD_W-1:0] src;
  always_comb begin
    src     = size_byte ? {{(WORD_W-BYTE_W){1'b0}}, operand[BYTE_W-1:0]} : operand;
    old_bit = src[idx];
    new_val = apply_op(op, src, idx);
    writes  = (op != OP_TEST);
  end

  // R3..R6: only the selected bit may differ
  always_comb begin
    a_single_bit_r6: assert ($countones(new_val ^ src) <= 1);
    if (op == OP_SET) a_set_r4: assert (new_val[idx] == 1'b1);
    if (op == OP_CLEAR) a_clr_r5: assert (new_val[idx] == 1'b0);
  end
endmodule

// File: rtl/bit_tmod_unit.sv
module bit_tmod_unit
  import bit_tmod_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid_in,
  input  logic [1:0]   opcode,
  input  logic         size_byte,
  input  logic         num_sel,
  input  logic [7:0]   imm_num,
  input  logic [31:0]  reg_num,
  input  logic [31:0]  operand,
  input  logic [3:0]   flags_in,
  output logic [31:0]  result,
  output logic         wr_en,
  output logic         z_out,
  output logic [3:0]   flags_out,
  output logic         done
);
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] new_val;
  logic              old_bit;
  logic              writes;
  bit_op_e           op;

  assign op = bit_op_e'(opcode);

  bit_index_sel #(.IMM_W(8), .REG_W(32)) u_idx (
    .num_sel(num_sel), .size_byte(size_byte),
    .imm_num(imm_num), .reg_num(reg_num), .idx(idx)
  );

  bit_alter_core u_core (
    .op(op), .size_byte(size_byte), .idx(idx), .operand(operand),
    .new_val(new_val), .old_bit(old_bit), .writes(writes)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      wr_en  <= 1'b0;
      z_out  <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= valid_in;
      if (valid_in) begin
        result <= new_val;
        wr_en  <= writes;
        z_out  <= ~old_bit;
      end
    end
  end

  assign flags_out = flags_in;

  a_done_r2: assert property (@(posedge clk) disable iff (!rst_n) valid_in |=> done);
  a_nodone_r2: assert property (@(posedge clk) disable iff (!rst_n) !valid_in |=> !done);
  a_test_nowr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && opcode == 2'b00) |=> !wr_en);
  a_test_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && opcode == 2'b00 && !size_byte) |=> result == $past(operand));
  a_byte_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && size_byte) |=> result[31:8] == 24'd0);
  a_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> ($stable(result) && $stable(z_out) && $stable(wr_en)));
endmodule

// File: tb/bit_tmod_unit_tb.sv
module bit_tmod_unit_tb;
  logic clk = 0, rst_n = 0, valid_in = 0, size_byte = 0, num_sel = 0;
  logic [1:0] opcode = 0;
  logic [7:0] imm_num = 0;
  logic [31:0] reg_num = 0, operand = 0;
  logic [3:0] flags_in = 0;
  logic [31:0] result;
  logic wr_en, z_out, done;
  logic [3:0] flags_out;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  bit_tmod_unit u_dut (.*);

  function automatic int exp_pos(input logic sb, input logic ns, input logic [7:0] im, input logic [31:0] rg);
    int n;
    n = ns ? int'(rg % 256) : int'(im);
    if (ns) n = int'(rg[7:0]);
    return sb ? (n % 8) : (n % 32);
  endfunction

  function automatic logic [31:0] exp_res(input logic [1:0] o, input logic sb, input logic [31:0] v, input int p);
    logic [31:0] b;
    b = sb ? {24'd0, v[7:0]} : v;
    case (o)
      2'd1: b[p] = 1'b1;
      2'd2: b[p] = 1'b0;
      2'd3: b[p] = ~b[p];
      default: ;
    endcase
    return b;
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, expv);
    end
  endtask

  task automatic run(input logic [1:0] o, input logic sb, input logic ns,
                     input logic [7:0] im, input logic [31:0] rg, input logic [31:0] v);
    int p;
    logic [31:0] src;
    p = exp_pos(sb, ns, im, rg);
    src = sb ? {24'd0, v[7:0]} : v;
    @(negedge clk);
    opcode = o; size_byte = sb; num_sel = ns; imm_num = im; reg_num = rg; operand = v;
    flags_in = 4'($urandom); valid_in = 1;
    #1 chk("R11 flags", {28'd0, flags_out}, {28'd0, flags_in});
    @(negedge clk);
    valid_in = 0;
    chk("R2 done", {31'd0, done}, 32'd1);
    chk("R3 z", {31'd0, z_out}, {31'd0, ~src[p]});
    chk(o == 0 ? "R7 test result" : (o == 1 ? "R4 set" : (o == 2 ? "R5 clear" : "R6 change")),
        result, exp_res(o, sb, v, p));
    chk("R7 wr_en", {31'd0, wr_en}, {31'd0, o != 2'd0});
    if (sb) chk("R8 upper zero", {8'd0, result[31:8]}, 32'd0);
    @(negedge clk);
    chk("R2 done low", {31'd0, done}, 32'd0);
    chk("R12 hold", result, exp_res(o, sb, v, p));
  endtask

  initial begin
    #100000000;
    fails++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #1;
    chk("R1 done", {31'd0, done}, 0);
    chk("R1 wr_en", {31'd0, wr_en}, 0);
    chk("R1 z", {31'd0, z_out}, 0);
    chk("R1 result", result, 0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    run(2'd1, 0, 0, 8'd31, 0, 32'h8000_0000);   // R4 bit already set: z=0
    run(2'd2, 0, 0, 8'd0, 0, 32'hFFFF_FFFE);    // R5 bit already clear: z=1
    run(2'd3, 1, 0, 8'd15, 0, 32'hDEAD_BE80);   // R8 mod 8 -> bit 7
    run(2'd0, 0, 1, 8'd0, 32'hFFFF_FF25, 32'h0000_0020); // R9 R10 -> bit 5
    run(2'd1, 1, 1, 8'd3, 32'h0000_000B, 32'hFFFF_FF00); // R10 reg -> bit 3
    run(2'd0, 1, 0, 8'd255, 0, 32'h1234_5680);  // R7 byte test
    // back-to-back requests: R2
    @(negedge clk);
    opcode = 2'd1; size_byte = 0; num_sel = 0; imm_num = 8'd4; operand = 0; valid_in = 1;
    @(negedge clk);
    opcode = 2'd3; imm_num = 8'd9; operand = 32'h0000_0200;
    chk("R2 b2b first", result, 32'h10);
    @(negedge clk);
    valid_in = 0;
    chk("R2 b2b second", result, 32'h0);
    chk("R3 b2b z", {31'd0, z_out}, 0);
    for (int k = 0; k < 300; k++)
      run(2'($urandom), 1'($urandom), 1'($urandom), 8'($urandom), $urandom, $urandom);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule